// File: doc/BRIEF.md
# Data-Strobe Serial Transmitter

This block accepts 4-bit parallel words from a link-side source on a slow system clock and sends them out as a two-line data-strobe serial stream. The data line carries each serial bit directly. The strobe line changes only when the data line does not, so that a receiver can rebuild the bit clock from the exclusive-OR of the two lines. A fast bit clock at four times the system clock, phase-aligned to it, times the serial output.

Each word carries its own speed select. At base speed only the two low bits of the word are sent, and each bit is held for two fast-clock cycles. At double speed all four bits are sent, one per fast-clock cycle. Either way, one word fills exactly one system-clock period, so a packet of back-to-back words leaves as one continuous stream. Both lines have an output-enable. The enables are high only while a packet is being sent, and the encoder starts every packet from both lines low.

Top module: `dstrobe_tx`

## Requirements
- R1: A synchronous active-high reset, held for at least one edge of each clock, leaves both serial lines low and both output-enables low.
- R2: A word with tx_en high is captured on a rising clk_sys edge, and its first serial bit appears on the lines after the first rising clk_fast edge that follows that clk_sys edge.
- R3: At base speed (tx_speed = 0) only tx_data bit 0 and then bit 1 are sent, and each bit lasts two clk_fast cycles.
- R4: At double speed (tx_speed = 1) tx_data bits 0, 1, 2 and 3 are sent in that order, and each bit lasts one clk_fast cycle.
- R5: In every bit period ser_data equals the bit being sent. ser_strobe inverts when that bit equals the previous one and holds otherwise.
- R6: At most one of ser_data and ser_strobe changes on any clk_fast edge while the enables are high. At base speed neither line changes in the second cycle of a bit.
- R7: While no captured word has tx_en high, both output-enables are low and both lines are low. The two enables are always equal.
- R8: Every packet starts from data and strobe both low, so exactly one line is high in the first bit period after the enables rise.
- R9: Consecutive valid words leave as an unbroken stream, one system-clock period per word, with the speed taken from each word separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; parallel words are captured on its rising edge |
| clk_fast | input | 1 | Bit clock at four times clk_sys, phase-aligned to it |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| tx_data | input | 4 | Parallel word; bit 0 is sent first |
| tx_en | input | 1 | Word valid / transmit enable |
| tx_speed | input | 1 | 0 = base speed (2 bits per word), 1 = double speed (4 bits per word) |
| ser_data | output | 1 | Serial data line |
| ser_data_oe | output | 1 | Output-enable for the data line |
| ser_strobe | output | 1 | Serial strobe line |
| ser_strobe_oe | output | 1 | Output-enable for the strobe line |

## Verification
On every fast-clock cycle the assertions check these properties at the ports: the reset state, equal enables, both lines low while idle, at most one line changing per edge, and exactly one line high on the first bit of a packet. Which bits go out, in what order, how long each is held, the strobe values, the latency from capture, and the join between consecutive words at different speeds can only be shown by the bench. It does so by decoding the captured stream against expected sequences that it computes for every word value at both speeds and for several multi-word packets.

// File: rtl/dstrobe_tx_pkg.sv
package dstrobe_tx_pkg;

    // Parallel word width; also the number of fast cycles per system cycle.
    localparam int WORD_W = 4;
    localparam int SLOT_W = $clog2(WORD_W);

    typedef enum logic {
        SPD_BASE   = 1'b0,
        SPD_DOUBLE = 1'b1
    } speed_e;

    typedef struct packed {
        logic                valid;
        speed_e              speed;
        logic [WORD_W-1:0]   data;
    } word_t;

    // Index of the bit sent during a given fast-cycle slot.
    function automatic logic [SLOT_W-1:0] slot_bit_index(speed_e spd, logic [SLOT_W-1:0] slot);
        if (spd == SPD_DOUBLE)
            return slot;
        else
            return slot >> 1;
    endfunction

    // True when a slot opens a new bit period.
    function automatic logic slot_opens_bit(speed_e spd, logic [SLOT_W-1:0] slot);
        if (spd == SPD_DOUBLE)
            return 1'b1;
        else
            return ~slot[0];
    endfunction

endpackage

// File: rtl/dstrobe_tx_capture.sv
module dstrobe_tx_capture
    import dstrobe_tx_pkg::*;
(
    input  logic              clk_sys,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_speed,
    output word_t             word_q,
    output logic              toggle_q
);

    always_ff @(posedge clk_sys) begin
        if (rst) begin
            word_q   <= '0;
            toggle_q <= 1'b0;
        end else begin
            word_q.valid <= in_valid;
            word_q.speed <= speed_e'(in_speed);
            word_q.data  <= in_data;
            toggle_q     <= ~toggle_q;
        end
    end

endmodule

// File: rtl/dstrobe_tx_slotter.sv
module dstrobe_tx_slotter
    import dstrobe_tx_pkg::*;
(
    input  logic  clk_fast,
    input  logic  rst,
    input  word_t word_in,
    input  logic  toggle_in,
    output logic  active,
    output logic  bit_start,
    output logic  bit_val
);

    logic              seen_q;
    word_t             held_q;
    logic [SLOT_W-1:0] slot_q;

    logic              load;
    word_t             eff_word;
    logic [SLOT_W-1:0] eff_slot;
    logic [SLOT_W-1:0] idx;

    // A new system-clock word is announced by a change of the toggle.
    assign load     = (toggle_in != seen_q);
    assign eff_word = load ? word_in : held_q;
    assign eff_slot = load ? '0 : slot_q;
    assign idx      = slot_bit_index(eff_word.speed, eff_slot);

    assign active    = eff_word.valid;
    assign bit_start = slot_opens_bit(eff_word.speed, eff_slot);
    assign bit_val   = eff_word.data[idx];

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            seen_q <= 1'b0;
            held_q <= '0;
            slot_q <= '0;
        end else begin
            seen_q <= toggle_in;
            held_q <= eff_word;
            slot_q <= eff_slot + 1'b1;
        end
    end

endmodule

// File: rtl/dstrobe_tx_encoder.sv
module dstrobe_tx_encoder (
    input  logic clk_fast,
    input  logic rst,
    input  logic active,
    input  logic bit_start,
    input  logic bit_val,
    output logic line_d,
    output logic line_s,
    output logic line_oe
);

    always_ff @(posedge clk_fast) begin
        if (rst || !active) begin
            line_d  <= 1'b0;
            line_s  <= 1'b0;
            line_oe <= 1'b0;
        end else begin
            line_oe <= 1'b1;
            if (bit_start) begin
                if (bit_val == line_d)
                    line_s <= ~line_s;
                else
                    line_d <= bit_val;
            end
        end
    end

endmodule

// File: rtl/dstrobe_tx.sv
module dstrobe_tx
    import dstrobe_tx_pkg::*;
(
    input  logic              clk_sys,
    input  logic              clk_fast,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_en,
    input  logic              tx_speed,
    output logic              ser_data,
    output logic              ser_data_oe,
    output logic              ser_strobe,
    output logic              ser_strobe_oe
);

    word_t cap_word;
    logic  cap_toggle;
    logic  enc_active;
    logic  enc_start;
    logic  enc_bit;
    logic  enc_oe;

    dstrobe_tx_capture u_capture (
        .clk_sys  (clk_sys),
        .rst      (rst),
        .in_data  (tx_data),
        .in_valid (tx_en),
        .in_speed (tx_speed),
        .word_q   (cap_word),
        .toggle_q (cap_toggle)
    );

    dstrobe_tx_slotter u_slotter (
        .clk_fast  (clk_fast),
        .rst       (rst),
        .word_in   (cap_word),
        .toggle_in (cap_toggle),
        .active    (enc_active),
        .bit_start (enc_start),
        .bit_val   (enc_bit)
    );

    dstrobe_tx_encoder u_encoder (
        .clk_fast  (clk_fast),
        .rst       (rst),
        .active    (enc_active),
        .bit_start (enc_start),
        .bit_val   (enc_bit),
        .line_d    (ser_data),
        .line_s    (ser_strobe),
        .line_oe   (enc_oe)
    );

    assign ser_data_oe   = enc_oe;
    assign ser_strobe_oe = enc_oe;

endmodule

// File: rtl/dstrobe_tx_checker.sv
module dstrobe_tx_checker (
    input logic clk_fast,
    input logic rst,
    input logic ser_data,
    input logic ser_data_oe,
    input logic ser_strobe,
    input logic ser_strobe_oe
);

    assert_reset_quiet_R1: assert property (@(posedge clk_fast)
        rst |=> (!ser_data && !ser_strobe && !ser_data_oe && !ser_strobe_oe));

    assert_enables_equal_R7: assert property (@(posedge clk_fast) disable iff (rst)
        ser_data_oe == ser_strobe_oe);

    assert_idle_low_R7: assert property (@(posedge clk_fast) disable iff (rst)
        !ser_data_oe |-> (!ser_data && !ser_strobe));

    assert_single_change_R6: assert property (@(posedge clk_fast) disable iff (rst)
        (ser_data_oe && $past(ser_data_oe)) |->
            ($countones({ser_data ^ $past(ser_data), ser_strobe ^ $past(ser_strobe)}) <= 1));

    assert_packet_start_R8: assert property (@(posedge clk_fast) disable iff (rst)
        $rose(ser_data_oe) |-> (ser_data != ser_strobe));

endmodule

bind dstrobe_tx dstrobe_tx_checker u_checker (
    .clk_fast      (clk_fast),
    .rst           (rst),
    .ser_data      (ser_data),
    .ser_data_oe   (ser_data_oe),
    .ser_strobe    (ser_strobe),
    .ser_strobe_oe (ser_strobe_oe)
);

// File: tb/dstrobe_tx_tb.sv
module dstrobe_tx_tb_top;

    localparam int FAST_PERIOD = 10;
    localparam int SYS_PERIOD  = 4 * FAST_PERIOD;

    logic       clk_sys  = 1'b0;
    logic       clk_fast = 1'b0;
    logic       rst      = 1'b1;
    logic [3:0] tx_data  = '0;
    logic       tx_en    = 1'b0;
    logic       tx_speed = 1'b0;
    logic       ser_data, ser_data_oe, ser_strobe, ser_strobe_oe;

    int checks = 0;
    int fails  = 0;

    dstrobe_tx dut_i (
        .clk_sys       (clk_sys),
        .clk_fast      (clk_fast),
        .rst           (rst),
        .tx_data       (tx_data),
        .tx_en         (tx_en),
        .tx_speed      (tx_speed),
        .ser_data      (ser_data),
        .ser_data_oe   (ser_data_oe),
        .ser_strobe    (ser_strobe),
        .ser_strobe_oe (ser_strobe_oe)
    );

    // Fast rises at 5,15,25..; system rises at 25,65.. (aligned with fast).
    always #(FAST_PERIOD/2) clk_fast = ~clk_fast;
    initial begin
        #(FAST_PERIOD/2);
        forever #(SYS_PERIOD/2) clk_sys = ~clk_sys;
    end

    // Stream capture at fast falling edges.
    logic   cap_d [256];
    logic   cap_s [256];
    int     cap_n = 0;
    longint first_t = -1;

    always @(negedge clk_fast) begin
        if (!rst && ser_data_oe && cap_n < 256) begin
            if (cap_n == 0) first_t = $time;
            cap_d[cap_n] = ser_data;
            cap_s[cap_n] = ser_strobe;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [3:0] pw [8];
    logic       ps [8];

    task automatic send_packet(input int n, input string req);
        logic   ed [256];
        logic   es [256];
        int     ne = 0;
        logic   pd = 1'b0;
        logic   pst = 1'b0;
        int     bad_d = 0;
        int     bad_s = 0;
        longint t0 = 0;
        // expected stream
        for (int w = 0; w < n; w++) begin
            int nb = ps[w] ? 4 : 2;
            int hold = ps[w] ? 1 : 2;
            for (int b = 0; b < nb; b++) begin
                logic bv = pw[w][b];
                if (bv == pd) pst = ~pst;
                pd = bv;
                for (int h = 0; h < hold; h++) begin
                    ed[ne] = pd;
                    es[ne] = pst;
                    ne++;
                end
            end
        end
        cap_n   = 0;
        first_t = -1;
        @(negedge clk_sys);
        for (int w = 0; w < n; w++) begin
            tx_data  = pw[w];
            tx_speed = ps[w];
            tx_en    = 1'b1;
            @(posedge clk_sys);
            if (w == 0) t0 = $time;
            @(negedge clk_sys);
        end
        tx_en   = 1'b0;
        tx_data = '0;
        repeat (3) @(negedge clk_sys);
        check(cap_n == ne, req, "stream length (R9)", cap_n, ne);
        check(first_t == t0 + FAST_PERIOD + FAST_PERIOD/2, "R2", "first bit time",
              first_t, t0 + FAST_PERIOD + FAST_PERIOD/2);
        for (int i = 0; i < ne && i < cap_n; i++) begin
            if (cap_d[i] !== ed[i]) bad_d++;
            if (cap_s[i] !== es[i]) bad_s++;
        end
        check(bad_d == 0, req, "data line mismatches", bad_d, 0);
        check(bad_s == 0, "R5", "strobe line mismatches (R6 R8)", bad_s, 0);
        check(ser_data_oe == 1'b0 && ser_strobe_oe == 1'b0 && ser_data == 1'b0 && ser_strobe == 1'b0,
              "R7", "idle after packet", {ser_data_oe, ser_strobe_oe, ser_data, ser_strobe}, 0);
    endtask

    initial begin
        #(FAST_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_sys);
        // R1: reset state
        check({ser_data, ser_strobe, ser_data_oe, ser_strobe_oe} == 4'b0, "R1", "reset outputs",
              {ser_data, ser_strobe, ser_data_oe, ser_strobe_oe}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk_sys);
        // R7: idle with tx_en low, data toggling
        tx_data = 4'hF;
        tx_speed = 1'b1;
        repeat (2) @(negedge clk_sys);
        check({ser_data, ser_strobe, ser_data_oe, ser_strobe_oe} == 4'b0, "R7", "idle ignores data",
              {ser_data, ser_strobe, ser_data_oe, ser_strobe_oe}, 0);
        // Exhaustive single words: R3 at base, R4 at double
        for (int v = 0; v < 16; v++) begin
            for (int sp = 0; sp < 2; sp++) begin
                pw[0] = 4'(v);
                ps[0] = sp[0];
                send_packet(1, sp ? "R4" : "R3");
            end
        end
        // Repeated bits: strobe toggles each period
        for (int w = 0; w < 4; w++) begin pw[w] = 4'h0; ps[w] = 1'b1; end
        send_packet(4, "R5");
        for (int w = 0; w < 4; w++) begin pw[w] = 4'hF; ps[w] = 1'b0; end
        send_packet(4, "R5");
        // Alternating bits
        for (int w = 0; w < 4; w++) begin pw[w] = 4'h5; ps[w] = 1'b1; end
        send_packet(4, "R6");
        // Mixed speeds within a packet
        for (int w = 0; w < 8; w++) begin pw[w] = 4'(w * 3 + 1); ps[w] = w[0]; end
        send_packet(8, "R9");
        for (int w = 0; w < 8; w++) begin pw[w] = 4'(15 - w * 2); ps[w] = (w % 3 == 0); end
        send_packet(8, "R9");
        // Back-to-back packets reset encoder state
        pw[0] = 4'hA; ps[0] = 1'b1;
        send_packet(1, "R8");
        pw[0] = 4'hA; ps[0] = 1'b1;
        send_packet(1, "R8");
        // Reset in the middle of a packet
        @(negedge clk_sys);
        tx_en = 1'b1; tx_data = 4'h9; tx_speed = 1'b1;
        repeat (2) @(negedge clk_sys);
        rst = 1'b1;
        @(negedge clk_sys);
        check({ser_data, ser_strobe, ser_data_oe, ser_strobe_oe} == 4'b0, "R1", "mid-packet reset",
              {ser_data, ser_strobe, ser_data_oe, ser_strobe_oe}, 0);
        tx_en = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk_sys);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule